// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each incoming frame, whether the receiver keeps it. It looks at two things only: the frame length (counted without the trailing checksum) and the 48-bit destination address. A set of receive control flags chooses which classes of frame are welcome: short frames, any unicast frame, any group frame, and the all-ones address. A frame that no class claims can still be accepted if its destination exactly equals one of 16 programmed station addresses. Each of those addresses can be switched on or off by a bit in an enable mask.

Software programs the address table through a write port. Each write carries an entry index and three 16-bit words, and the cycle after each write a one-cycle load-done pulse appears. While the chip is held in reset mode, any entry can be read back through three read-only words that are selected by an entry pointer. The frame side uses a single valid strobe. One cycle after the strobe the block gives exactly one of an accept strobe or a reject strobe. When the frame is accepted it also gives a group flag or a broadcast flag, as the rules below decide.

Top module: `rx_addr_filter`

## Requirements
- R1: A frame with length below 60 bytes is short. It is accepted with both type flags low when control bit 14 is set, and rejected otherwise. This test is made before every other test, so a short frame is never accepted by any later rule and never raises a type flag.
- R2: With control bit 12 set, a frame of at least 60 bytes whose first destination byte (address bits 47:40) has bit 0 clear is accepted with both flags low.
- R3: With control bit 11 set, a frame of at least 60 bytes whose first destination byte has bit 0 set is accepted with the group flag high and the broadcast flag low. This rule ranks above R4, so an all-ones destination that reaches this rule raises the group flag and not the broadcast flag.
- R4: With control bit 13 set, a frame of at least 60 bytes whose destination is all ones, and which no earlier rule has claimed, is accepted with the broadcast flag high and the group flag low.
- R5: A frame of at least 60 bytes that no earlier rule claims is accepted, with both flags low, when its destination exactly equals table entry i and bit i of the enable mask is set. A disabled entry never matches.
- R6: A table write with index i and words w0, w1, w2 stores address byte 2k in the low byte of wk and byte 2k+1 in its high byte, where byte 0 is the first destination byte. One cycle after the write, load_done is high for one cycle.
- R7: Read-back word k returns {byte 2k+1, byte 2k} of the entry chosen by the low 4 bits of the pointer input; the upper pointer bits have no effect. All three words read zero whenever reset mode is low.
- R8: Exactly one of accept or reject pulses for one cycle, one clock edge after each frame-valid strobe, and neither pulses at any other time. A rejected frame has both flags low. The flags are never both high.
- R9: A table or mask write made in the same cycle as a frame strobe does not affect that frame. The frame is judged on the contents held before that clock edge.
- R10: After reset, every table entry and the enable mask are zero, and accept, reject, both flags and load_done are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reset_mode | input | 1 | Chip reset-mode bit; enables read-back |
| rx_ctl | input | 16 | Receive control flags (bits 14, 13, 12, 11 used) |
| frm_valid | input | 1 | Frame strobe: dst and length are valid |
| frm_dst | input | 48 | Destination address, first byte in bits 47:40 |
| frm_len | input | 16 | Frame length in bytes, checksum excluded |
| tbl_wr | input | 1 | Table write strobe |
| tbl_idx | input | 4 | Entry to write |
| tbl_w0 | input | 16 | Address bytes 1:0 (high:low) |
| tbl_w1 | input | 16 | Address bytes 3:2 |
| tbl_w2 | input | 16 | Address bytes 5:4 |
| mask_wr | input | 1 | Enable-mask write strobe |
| mask_data | input | 16 | New enable mask |
| rd_ptr | input | 16 | Read-back entry pointer; low 4 bits used |
| rd_w0 | output | 16 | Read-back bytes 1:0 |
| rd_w1 | output | 16 | Read-back bytes 3:2 |
| rd_w2 | output | 16 | Read-back bytes 5:4 |
| load_done | output | 1 | One-cycle pulse after a table write |
| rx_accept | output | 1 | Frame accepted strobe |
| rx_reject | output | 1 | Frame rejected strobe |
| rx_mcast | output | 1 | Accepted as group frame |
| rx_bcast | output | 1 | Accepted as broadcast frame |

## Verification
Two things can land in the same cycle: a table or mask write, and a frame strobe that looks for the address being written. The bench provokes this by driving both strobes on one edge. In the first case it writes an enabled but still empty entry with the frame's own destination. In the second it clears the mask bit of an entry that matches the frame. In both cases the scoreboard expects the verdict based on the old contents, and then sends the same frame again on the next cycle to confirm that the new contents now decide. Priority collisions are provoked the same way: a short all-ones frame, and an all-ones frame with both the group and broadcast rules switched on, are each checked for the single flag that the priority order leaves standing.

// File: rtl/afilt_pkg.sv
package afilt_pkg;
  localparam int unsigned CTL_RUNT_OK = 14;
  localparam int unsigned CTL_BCAST   = 13;
  localparam int unsigned CTL_PROMISC = 12;
  localparam int unsigned CTL_ALL_MC  = 11;

  typedef struct packed {
    logic acc;
    logic mc;
    logic bc;
  } verdict_t;

  // Three 16-bit words (low byte = earlier address byte) to a 48-bit address
  // with byte 0 in the top bits.
  function automatic logic [47:0] words_to_addr(input logic [15:0] w0,
                                                input logic [15:0] w1,
                                                input logic [15:0] w2);
    return {w0[7:0], w0[15:8], w1[7:0], w1[15:8], w2[7:0], w2[15:8]};
  endfunction

  // Word k of an address: {byte 2k+1, byte 2k}.
  function automatic logic [15:0] addr_word(input logic [47:0] a,
                                            input int unsigned k);
    logic [7:0] lo;
    logic [7:0] hi;
    lo = a[47 - 16*k -: 8];
    hi = a[39 - 16*k -: 8];
    return {hi, lo};
  endfunction

  function automatic logic is_group(input logic [47:0] a);
    return a[40];
  endfunction

  function automatic logic is_all_ones(input logic [47:0] a);
    return &a;
  endfunction

  // Priority decision: short, unicast-any, group-any, broadcast, table hit.
  function automatic verdict_t judge(input logic        short_frm,
                                     input logic [15:0] ctl,
                                     input logic [47:0] dst,
                                     input logic        tbl_hit);
    verdict_t v;
    v = '0;
    if (short_frm) begin
      v.acc = ctl[CTL_RUNT_OK];
    end else if (ctl[CTL_PROMISC] && !is_group(dst)) begin
      v.acc = 1'b1;
    end else if (ctl[CTL_ALL_MC] && is_group(dst)) begin
      v.acc = 1'b1;
      v.mc  = 1'b1;
    end else if (ctl[CTL_BCAST] && is_all_ones(dst)) begin
      v.acc = 1'b1;
      v.bc  = 1'b1;
    end else begin
      v.acc = tbl_hit;
    end
    return v;
  endfunction
endpackage

// File: rtl/afilt_cam.sv
module afilt_cam #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ADDR_W  = 48,
  parameter int unsigned WORD_W  = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic                 mask_wr,
  input  logic [ENTRIES-1:0]   mask_in,
  input  logic [ADDR_W-1:0]    key,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [ADDR_W-1:0]    rd_addr,
  output logic [ENTRIES-1:0]   hit_vec,
  output logic [ENTRIES-1:0]   en_mask
);
  logic [ADDR_W-1:0] entry_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_mask <= '0;
    else if (mask_wr) en_mask <= mask_in;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entry_q[i] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(i))) entry_q[i] <= wr_addr;
    end
    assign hit_vec[i] = en_mask[i] && (entry_q[i] == key);
  end

  assign rd_addr = entry_q[rd_idx];
endmodule

// File: rtl/afilt_decide.sv
module afilt_decide
  import afilt_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned MIN_LEN = 60
) (
  input  logic [15:0]        ctl,
  input  logic [47:0]        dst,
  input  logic [LEN_W-1:0]   len,
  input  logic [ENTRIES-1:0] hit_vec,
  output logic               short_frm,
  output logic               tbl_hit,
  output verdict_t           verdict
);
  assign short_frm = (len < LEN_W'(MIN_LEN));
  assign tbl_hit   = |hit_vec;
  assign verdict   = judge(short_frm, ctl, dst, tbl_hit);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import afilt_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned MIN_LEN = 60,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reset_mode,
  input  logic [15:0]        rx_ctl,
  input  logic               frm_valid,
  input  logic [47:0]        frm_dst,
  input  logic [LEN_W-1:0]   frm_len,
  input  logic               tbl_wr,
  input  logic [IDX_W-1:0]   tbl_idx,
  input  logic [15:0]        tbl_w0,
  input  logic [15:0]        tbl_w1,
  input  logic [15:0]        tbl_w2,
  input  logic               mask_wr,
  input  logic [ENTRIES-1:0] mask_data,
  input  logic [15:0]        rd_ptr,
  output logic [15:0]        rd_w0,
  output logic [15:0]        rd_w1,
  output logic [15:0]        rd_w2,
  output logic               load_done,
  output logic               rx_accept,
  output logic               rx_reject,
  output logic               rx_mcast,
  output logic               rx_bcast
);
  // Named internal events for the checker.
  logic [47:0]        wr_addr;
  logic [47:0]        rd_addr;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] en_mask;
  logic               short_frm;
  logic               tbl_hit;
  verdict_t           verdict;

  assign wr_addr = words_to_addr(tbl_w0, tbl_w1, tbl_w2);

  afilt_cam #(.ENTRIES(ENTRIES), .ADDR_W(48), .WORD_W(16)) u_cam (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_wr),
    .wr_idx  (tbl_idx),
    .wr_addr (wr_addr),
    .mask_wr (mask_wr),
    .mask_in (mask_data),
    .key     (frm_dst),
    .rd_idx  (rd_ptr[IDX_W-1:0]),
    .rd_addr (rd_addr),
    .hit_vec (hit_vec),
    .en_mask (en_mask)
  );

  afilt_decide #(.ENTRIES(ENTRIES), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_dec (
    .ctl       (rx_ctl),
    .dst       (frm_dst),
    .len       (frm_len),
    .hit_vec   (hit_vec),
    .short_frm (short_frm),
    .tbl_hit   (tbl_hit),
    .verdict   (verdict)
  );

  assign rd_w0 = reset_mode ? addr_word(rd_addr, 0) : 16'h0000;
  assign rd_w1 = reset_mode ? addr_word(rd_addr, 1) : 16'h0000;
  assign rd_w2 = reset_mode ? addr_word(rd_addr, 2) : 16'h0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_done <= 1'b0;
      rx_accept <= 1'b0;
      rx_reject <= 1'b0;
      rx_mcast  <= 1'b0;
      rx_bcast  <= 1'b0;
    end else begin
      load_done <= tbl_wr;
      rx_accept <= frm_valid &&  verdict.acc;
      rx_reject <= frm_valid && !verdict.acc;
      rx_mcast  <= frm_valid &&  verdict.acc && verdict.mc;
      rx_bcast  <= frm_valid &&  verdict.acc && verdict.bc;
    end
  end
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned MIN_LEN = 60
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reset_mode,
  input logic [15:0]        rx_ctl,
  input logic               frm_valid,
  input logic [47:0]        frm_dst,
  input logic [LEN_W-1:0]   frm_len,
  input logic               tbl_wr,
  input logic [15:0]        rd_w0,
  input logic [15:0]        rd_w1,
  input logic [15:0]        rd_w2,
  input logic               load_done,
  input logic               rx_accept,
  input logic               rx_reject,
  input logic               rx_mcast,
  input logic               rx_bcast,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] en_mask
);
  p_short_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_len < LEN_W'(MIN_LEN) && !rx_ctl[14]) |=> rx_reject);

  p_short_noflag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_len < LEN_W'(MIN_LEN) && rx_ctl[14])
      |=> (rx_accept && !rx_mcast && !rx_bcast));

  p_promisc_ucast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_len >= LEN_W'(MIN_LEN) && rx_ctl[12] && !frm_dst[40])
      |=> (rx_accept && !rx_mcast && !rx_bcast));

  p_group_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_len >= LEN_W'(MIN_LEN) && rx_ctl[11] && frm_dst[40])
      |=> (rx_accept && rx_mcast));

  p_bcast_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_len >= LEN_W'(MIN_LEN) && rx_ctl[13] && !rx_ctl[11] && (&frm_dst))
      |=> (rx_accept && rx_bcast));

  p_hit_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~en_mask) == '0);

  p_load_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr |=> load_done);

  p_load_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_wr |=> !load_done);

  p_rd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_mode |-> (rd_w0 == 16'h0 && rd_w1 == 16'h0 && rd_w2 == 16'h0));

  p_one_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> (rx_accept != rx_reject));

  p_no_stray_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> (!rx_accept && !rx_reject));

  p_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rx_mcast, rx_bcast, rx_reject}) <= 1);
endmodule

bind rx_addr_filter rx_addr_filter_chk #(
  .ENTRIES(ENTRIES), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode), .rx_ctl(rx_ctl),
  .frm_valid(frm_valid), .frm_dst(frm_dst), .frm_len(frm_len),
  .tbl_wr(tbl_wr), .rd_w0(rd_w0), .rd_w1(rd_w1), .rd_w2(rd_w2),
  .load_done(load_done), .rx_accept(rx_accept), .rx_reject(rx_reject),
  .rx_mcast(rx_mcast), .rx_bcast(rx_bcast), .hit_vec(hit_vec),
  .en_mask(en_mask)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_mode = 1'b1;
  logic [15:0] rx_ctl = '0;
  logic        frm_valid = 1'b0;
  logic [47:0] frm_dst = '0;
  logic [15:0] frm_len = '0;
  logic        tbl_wr = 1'b0;
  logic [3:0]  tbl_idx = '0;
  logic [15:0] tbl_w0 = '0, tbl_w1 = '0, tbl_w2 = '0;
  logic        mask_wr = 1'b0;
  logic [15:0] mask_data = '0;
  logic [15:0] rd_ptr = '0;
  logic [15:0] rd_w0, rd_w1, rd_w2;
  logic        load_done, rx_accept, rx_reject, rx_mcast, rx_bcast;

  always #2 clk = ~clk;

  rx_addr_filter u_dut (.*);

  typedef struct {
    bit    acc;
    bit    mc;
    bit    bc;
    string tag;
  } exp_t;

  exp_t        exp_q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          mon_on = 1'b0;
  logic [47:0] mdl_tbl [16];
  logic [15:0] mdl_mask = '0;

  task automatic check(input bit ok, input string tag, input logic [47:0] act,
                       input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference written from the requirement list.
  function automatic exp_t ref_eval(input logic [47:0] d, input logic [15:0] l,
                                    input logic [15:0] c, input string tag);
    exp_t e;
    bit   hit;
    e = '{acc: 0, mc: 0, bc: 0, tag: tag};
    hit = 0;
    for (int i = 0; i < 16; i++)
      if (mdl_mask[i] && mdl_tbl[i] == d) hit = 1;
    if (l < 60) begin
      e.acc = c[14];
      return e;
    end
    if (c[12] && d[40] == 1'b0) begin e.acc = 1; return e; end
    if (c[11] && d[40] == 1'b1) begin e.acc = 1; e.mc = 1; return e; end
    if (c[13] && d == '1) begin e.acc = 1; e.bc = 1; return e; end
    e.acc = hit;
    return e;
  endfunction

  // Monitor: results appear one edge after the strobe.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on) begin
        if (exp_q.size() != 0) begin
          exp_t e;
          e = exp_q.pop_front();
          check(rx_accept == e.acc && rx_reject == !e.acc && rx_mcast == e.mc
                && rx_bcast == e.bc, e.tag,
                {44'h0, rx_accept, rx_reject, rx_mcast, rx_bcast},
                {44'h0, e.acc, !e.acc, e.mc, e.bc});
        end else if (rx_accept || rx_reject) begin
          check(1'b0, "R8 stray verdict", {46'h0, rx_accept, rx_reject}, 48'h0);
        end
      end
    end
  end

  function automatic logic [15:0] wd(input logic [47:0] a, input int k);
    logic [7:0] b0, b1;
    b0 = a[47-16*k -: 8];
    b1 = a[39-16*k -: 8];
    return {b1, b0};
  endfunction

  task automatic load(input int idx, input logic [47:0] a);
    @(negedge clk);
    tbl_wr = 1; tbl_idx = 4'(idx);
    tbl_w0 = wd(a, 0); tbl_w1 = wd(a, 1); tbl_w2 = wd(a, 2);
    @(posedge clk);
    mdl_tbl[idx] = a;
    #1;
    check(load_done == 1'b1, "R6 load_done pulse", {47'h0, load_done}, 48'h1);
    @(negedge clk);
    tbl_wr = 0;
    @(posedge clk); #1;
    check(load_done == 1'b0, "R6 load_done one cycle", {47'h0, load_done}, 48'h0);
  endtask

  task automatic set_mask(input logic [15:0] m);
    @(negedge clk);
    mask_wr = 1; mask_data = m;
    @(posedge clk);
    mdl_mask = m;
    @(negedge clk);
    mask_wr = 0;
  endtask

  task automatic send(input logic [47:0] d, input logic [15:0] l,
                      input logic [15:0] c, input string tag);
    @(negedge clk);
    frm_valid = 1; frm_dst = d; frm_len = l; rx_ctl = c;
    exp_q.push_back(ref_eval(d, l, c, tag));
    @(negedge clk);
    frm_valid = 0;
  endtask

  localparam logic [47:0] A3  = 48'h02_11_22_33_44_55;
  localparam logic [47:0] A15 = 48'h0A_BC_DE_F0_12_34;
  localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MC  = 48'h01_00_5E_00_00_07;
  localparam logic [47:0] UC  = 48'h00_99_88_77_66_55;
  localparam logic [47:0] A5  = 48'h00_50_C2_11_22_33;

  initial begin
    fork
      begin
        for (int i = 0; i < 16; i++) mdl_tbl[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check(!rx_accept && !rx_reject && !rx_mcast && !rx_bcast && !load_done,
              "R10 outputs in reset", {43'h0, rx_accept, rx_reject, rx_mcast,
              rx_bcast, load_done}, 48'h0);
        @(negedge clk); rst_n = 1;
        rd_ptr = 16'h0007; #1;
        check({rd_w0, rd_w1, rd_w2} == 48'h0, "R10 table cleared",
              {rd_w0, rd_w1, rd_w2}, 48'h0);
        mon_on = 1;
        send(A3, 16'd64, 16'h0, "R10 mask zero rejects");

        load(3, A3);
        @(negedge clk); rd_ptr = 16'h0003; #1;
        check(rd_w0 == 16'h1102 && rd_w1 == 16'h3322 && rd_w2 == 16'h5544,
              "R7 readback bytes", {rd_w0, rd_w1, rd_w2}, 48'h1102_3322_5544);
        rd_ptr = 16'hFFF3; #1;
        check(rd_w0 == 16'h1102, "R7 upper pointer bits ignored",
              {32'h0, rd_w0}, 48'h1102);
        reset_mode = 0; #1;
        check({rd_w0, rd_w1, rd_w2} == 48'h0, "R7 zero outside reset mode",
              {rd_w0, rd_w1, rd_w2}, 48'h0);
        reset_mode = 1;
        load(15, A15);

        send(A3, 16'd64, 16'h0, "R5 disabled entry");
        set_mask(16'h0010);
        send(A3, 16'd64, 16'h0, "R5 other entry enabled");
        set_mask(16'h8008);
        send(A3, 16'd64, 16'h0, "R5 entry 3 hit");
        send(A15, 16'd1500, 16'h0, "R5 entry 15 hit");
        send(A3 ^ 48'h1, 16'd64, 16'h0, "R5 near miss");

        send(A3, 16'd59, 16'h0, "R1 short rejected despite hit");
        send(BC, 16'd59, 16'h6800, "R1 short accepted no flag");
        send(A3, 16'd60, 16'h0, "R1 length 60 not short");

        send(UC, 16'd100, 16'h1000, "R2 promisc unicast");
        send(MC, 16'd100, 16'h1000, "R2 promisc ignores group");
        send(MC, 16'd100, 16'h0800, "R3 group accepted");
        send(BC, 16'd100, 16'h2800, "R3 group outranks broadcast");
        send(BC, 16'd100, 16'h2000, "R4 broadcast flag");
        send(BC, 16'd100, 16'h0000, "R4 broadcast off");
        send(UC, 16'd100, 16'h001F, "R4 low control bits no effect");

        // Back-to-back frames
        @(negedge clk);
        frm_valid = 1; frm_dst = A15; frm_len = 16'd80; rx_ctl = 16'h0;
        exp_q.push_back(ref_eval(A15, 16'd80, 16'h0, "R8 back-to-back first"));
        @(negedge clk);
        frm_dst = MC; rx_ctl = 16'h0800;
        exp_q.push_back(ref_eval(MC, 16'd80, 16'h0800, "R8 back-to-back second"));
        @(negedge clk);
        frm_valid = 0;

        // Same-cycle write and frame (R9)
        set_mask(16'h8028);
        @(negedge clk);
        frm_valid = 1; frm_dst = A5; frm_len = 16'd70; rx_ctl = 16'h0;
        exp_q.push_back(ref_eval(A5, 16'd70, 16'h0, "R9 write same cycle old table"));
        tbl_wr = 1; tbl_idx = 4'd5;
        tbl_w0 = wd(A5, 0); tbl_w1 = wd(A5, 1); tbl_w2 = wd(A5, 2);
        @(posedge clk); mdl_tbl[5] = A5;
        @(negedge clk);
        tbl_wr = 0;
        exp_q.push_back(ref_eval(A5, 16'd70, 16'h0, "R9 next frame new table"));
        @(negedge clk);
        frm_valid = 1; frm_dst = A3;
        exp_q.push_back(ref_eval(A3, 16'd70, 16'h0, "R9 mask clear same cycle"));
        mask_wr = 1; mask_data = 16'h8020;
        @(posedge clk); mdl_mask = 16'h8020;
        @(negedge clk);
        mask_wr = 0;
        exp_q.push_back(ref_eval(A3, 16'd70, 16'h0, "R9 next frame new mask"));
        @(negedge clk);
        frm_valid = 0;
        repeat (3) @(posedge clk);
        #1;
        check(exp_q.size() == 0, "R8 all verdicts seen", 48'(exp_q.size()), 48'h0);
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 48'h0, 48'h1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule